// File: doc/BRIEF.md
# Multiplexed LED Scan and Decode

This block drives an eight-digit seven-segment LED display from a small display memory that lives outside it. It lights one digit at a time in a fixed scrambled order. Between two lit digits it holds every digit line and every segment line dark for a short gap, so that the pattern of one digit never shows on the next. Both the lit time and the gap are counted in cycles of a single-cycle timing tick, and parameters set both counts.

For the digit being lit, the block drives a read address into the display memory and builds the segment pattern from the word that comes back. A per-digit flag chooses between a decoded character and raw segment bits. In decoded form, a global format input chooses the hexadecimal font or the Code B font, and a bank input chooses which of two stored nibbles is shown. The decimal point comes from the same bit in every format. A shutdown input stops the scan and darkens the display, and a blank input darkens the display while the scan keeps running, for use during a bulk memory load. A parameter sets the output polarity for common-anode or common-cathode parts.

Top module: `led_scan_decode`

## Requirements
- R1: After reset every digit and segment output is at its off level, and the scan begins with a gap that is followed by digit 2.
- R2: The timing counts only advance on cycles where `tick` is high. Each lit period lasts exactly ON_TICKS ticks and each gap lasts exactly GAP_TICKS ticks.
- R3: Lit digits repeat in the order 2, 5, 1, 7, 8, 6, 4, 3. Digit n is enabled on `digitOut[n-1]` and is read from memory address n-1, and at most one digit is enabled at a time.
- R4: During a gap all digit outputs and all segment outputs are at their off level.
- R5: Hex format (`fmtHex`=1) maps nibbles 0 to F onto the characters 0-9 and A, b, C, d, E, F. Segment bits are a=bit0 up to g=bit6, and the decimal point is bit 7.
- R6: Code B format (`fmtHex`=0) shows 0-9 for codes 0-9. Codes 10 to 15 show a dash (g only), E, H, L, P and a blank.
- R7: In raw form, word bits 6,5,4,3,2,1,0 drive segments a,b,c,e,g,f,d, where a 1 lights the segment. Word bit 7 lights the point when it is 0.
- R8: In decoded form the nibble is word bits 3:0 when `bankSel`=0 and word bits 11:8 when `bankSel`=1. The point is always taken from active-low bit 7, and bank select has no effect in raw form.
- R9: `digitDecode[n-1]`=1 decodes digit n, and 0 shows it raw. Each digit follows its own flag.
- R10: While `shutdown` is high all outputs are off one cycle later and the scan position freezes. After release the scan resumes the digit it stopped on.
- R11: While `blank` is high all outputs are off, but the scan keeps counting ticks.
- R12: With COMMON_ANODE=1 the segments are active low and the digits active high. With COMMON_ANODE=0 both polarities are inverted. Outputs are registered and lag their cause by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle timing pulse |
| shutdown | input | 1 | Stop the scan and darken the display |
| blank | input | 1 | Darken the display while the scan keeps running |
| fmtHex | input | 1 | 1 selects the hex font, 0 selects Code B |
| bankSel | input | 1 | 0 selects nibble bits 3:0, 1 selects bits 11:8 |
| digitDecode | input | 8 | Per-digit decode flag |
| rdAddr | output | 3 | Display memory read address |
| rdData | input | 12 | Display memory word for rdAddr, same cycle |
| digitOut | output | 8 | Digit enables at the chosen polarity |
| segOut | output | 8 | Segments a..g and point at the chosen polarity |

## Verification
The assertions assume that `tick` is a single-cycle pulse and that `rdData` answers `rdAddr` combinationally in the same cycle. They also assume that `shutdown` and `blank` are synchronous to `clk`. The bench drives each tick high for exactly one clock and follows it with idle clocks. It backs the read port with a combinational array, and it changes the control inputs only on falling edges. This keeps every input within those assumptions. A second instance built for common cathode shares all of these inputs, which shows the polarity inversion on the same scan.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

  localparam int NUM_DIGITS = 8;
  localparam int IDX_W      = $clog2(NUM_DIGITS);
  localparam int WORD_W     = 12;

  typedef enum logic {PH_GAP = 1'b0, PH_ON = 1'b1} scan_phase_e;

  typedef struct packed {
    logic             lit;
    logic [IDX_W-1:0] digitIdx;
  } scan_strobe_t;

  function automatic logic [IDX_W-1:0] slot_to_digit(input logic [IDX_W-1:0] slot);
    case (slot)
      3'd0:    return 3'd1;
      3'd1:    return 3'd4;
      3'd2:    return 3'd0;
      3'd3:    return 3'd6;
      3'd4:    return 3'd7;
      3'd5:    return 3'd5;
      3'd6:    return 3'd3;
      default: return 3'd2;
    endcase
  endfunction

  function automatic logic [6:0] hex_font(input logic [3:0] n);
    case (n)
      4'h0: return 7'h3F;
      4'h1: return 7'h06;
      4'h2: return 7'h5B;
      4'h3: return 7'h4F;
      4'h4: return 7'h66;
      4'h5: return 7'h6D;
      4'h6: return 7'h7D;
      4'h7: return 7'h07;
      4'h8: return 7'h7F;
      4'h9: return 7'h6F;
      4'hA: return 7'h77;
      4'hB: return 7'h7C;
      4'hC: return 7'h39;
      4'hD: return 7'h5E;
      4'hE: return 7'h79;
      default: return 7'h71;
    endcase
  endfunction

  function automatic logic [6:0] codeb_font(input logic [3:0] n);
    case (n)
      4'hA: return 7'h40;
      4'hB: return 7'h79;
      4'hC: return 7'h76;
      4'hD: return 7'h38;
      4'hE: return 7'h73;
      4'hF: return 7'h00;
      default: return hex_font(n);
    endcase
  endfunction

endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import led_scan_pkg::*;
#(
  parameter int ON_TICKS  = 320,
  parameter int GAP_TICKS = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         shutdown,
  input  logic         blank,
  output scan_strobe_t strobe
);

  localparam int CNT_MAX = (ON_TICKS > GAP_TICKS) ? ON_TICKS : GAP_TICKS;
  localparam int CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
  localparam logic [CNT_W-1:0] ON_LAST  = CNT_W'(ON_TICKS - 1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_TICKS - 1);

  scan_phase_e      phase;
  logic [CNT_W-1:0] tickCnt;
  logic [IDX_W-1:0] slot;
  logic [CNT_W-1:0] lastCnt;
  logic             advance;

  assign lastCnt = (phase == PH_ON) ? ON_LAST : GAP_LAST;
  assign advance = tick && !shutdown;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_GAP;
      tickCnt <= '0;
      slot    <= '0;
    end else if (advance) begin
      if (tickCnt == lastCnt) begin
        tickCnt <= '0;
        if (phase == PH_ON) begin
          phase <= PH_GAP;
          slot  <= slot + 1'b1;
        end else begin
          phase <= PH_ON;
        end
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  assign strobe.lit      = (phase == PH_ON) && !shutdown && !blank;
  assign strobe.digitIdx = slot_to_digit(slot);

  // R10: a held shutdown freezes the scan position
  a_r10_scan_frozen: assert property (@(posedge clk) disable iff (rst)
    shutdown |=> ($stable(slot) && $stable(tickCnt) && $stable(phase)));

  // R3: the slot steps only when a lit period ends on a tick
  a_r3_slot_steps_from_lit: assert property (@(posedge clk) disable iff (rst)
    (slot != $past(slot)) |-> ($past(phase) == PH_ON && $past(tick)));

  // R2: the count never passes the limit of the current phase
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    tickCnt <= lastCnt);

  // R2: without a tick the counter holds
  a_r2_tick_only: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(tickCnt));

endmodule

// File: rtl/seg_datapath.sv
module seg_datapath
  import led_scan_pkg::*;
#(
  parameter bit COMMON_ANODE = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  scan_strobe_t          strobe,
  input  logic                  fmtHex,
  input  logic                  bankSel,
  input  logic [NUM_DIGITS-1:0] digitDecode,
  output logic [IDX_W-1:0]      rdAddr,
  input  logic [WORD_W-1:0]     rdData,
  output logic [NUM_DIGITS-1:0] digitOut,
  output logic [7:0]            segOut
);

  localparam logic [7:0]            SEG_OFF = COMMON_ANODE ? 8'hFF : 8'h00;
  localparam logic [NUM_DIGITS-1:0] DIG_OFF = COMMON_ANODE ? '0 : '1;

  logic [3:0]            nibble;
  logic [6:0]            fontSeg;
  logic [6:0]            rawSeg;
  logic [7:0]            segOn;
  logic [7:0]            segAct;
  logic [NUM_DIGITS-1:0] digitHot;
  logic [7:0]            segLevel;
  logic [NUM_DIGITS-1:0] digitLevel;

  assign rdAddr  = strobe.digitIdx;
  assign nibble  = bankSel ? rdData[11:8] : rdData[3:0];
  assign fontSeg = fmtHex ? hex_font(nibble) : codeb_font(nibble);

  // raw word bits 6..0 carry segments a,b,c,e,g,f,d
  assign rawSeg = {rdData[2], rdData[1], rdData[3], rdData[0],
                   rdData[4], rdData[5], rdData[6]};

  assign segOn  = {~rdData[7], digitDecode[strobe.digitIdx] ? fontSeg : rawSeg};
  assign segAct = strobe.lit ? segOn : 8'h00;

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
    assign digitHot[d] = strobe.lit && (strobe.digitIdx == IDX_W'(d));
  end

  if (COMMON_ANODE) begin : g_anode
    assign segLevel   = ~segAct;
    assign digitLevel = digitHot;
  end else begin : g_cathode
    assign segLevel   = segAct;
    assign digitLevel = ~digitHot;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      segOut   <= SEG_OFF;
      digitOut <= DIG_OFF;
    end else begin
      segOut   <= segLevel;
      digitOut <= digitLevel;
    end
  end

  // R4, R10, R11: an unlit strobe darkens every output one clock later
  a_r4_dark_when_unlit: assert property (@(posedge clk) disable iff (rst)
    !strobe.lit |=> (segOut == SEG_OFF && digitOut == DIG_OFF));

  // R3: never more than one digit enabled
  a_r3_single_digit: assert property (@(posedge clk) disable iff (rst)
    $onehot0(digitOut ^ DIG_OFF));

  // R12: no segment is driven while every digit is off
  a_r12_segs_need_digit: assert property (@(posedge clk) disable iff (rst)
    (digitOut == DIG_OFF) |-> (segOut == SEG_OFF));

endmodule

// File: rtl/led_scan_decode.sv
module led_scan_decode
  import led_scan_pkg::*;
#(
  parameter int ON_TICKS     = 320,
  parameter int GAP_TICKS    = 10,
  parameter bit COMMON_ANODE = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        shutdown,
  input  logic        blank,
  input  logic        fmtHex,
  input  logic        bankSel,
  input  logic [7:0]  digitDecode,
  output logic [2:0]  rdAddr,
  input  logic [11:0] rdData,
  output logic [7:0]  digitOut,
  output logic [7:0]  segOut
);

  scan_strobe_t strobe;

  scan_ctrl #(
    .ON_TICKS (ON_TICKS),
    .GAP_TICKS(GAP_TICKS)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .shutdown(shutdown),
    .blank   (blank),
    .strobe  (strobe)
  );

  seg_datapath #(
    .COMMON_ANODE(COMMON_ANODE)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .fmtHex     (fmtHex),
    .bankSel    (bankSel),
    .digitDecode(digitDecode),
    .rdAddr     (rdAddr),
    .rdData     (rdData),
    .digitOut   (digitOut),
    .segOut     (segOut)
  );

endmodule

// File: tb/led_scan_decode_bench.sv
module led_scan_decode_bench;

  localparam int ON_T  = 3;
  localparam int GAP_T = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        shutdown = 1'b0;
  logic        blank = 1'b0;
  logic        fmtHex = 1'b1;
  logic        bankSel = 1'b0;
  logic [7:0]  digitDecode = 8'hFF;
  logic [2:0]  rdAddr, rdAddrCc;
  logic [11:0] rdData, rdDataCc;
  logic [7:0]  digitOut, segOut, digitOutCc, segOutCc;
  logic [11:0] mem [8];

  int checks = 0;
  int errors = 0;

  // bench scan model
  bit       mOn = 1'b0;
  int       mCnt = 0;
  int       mSlot = 0;
  localparam int ORDER [8] = '{1, 4, 0, 6, 7, 5, 3, 2};
  localparam logic [6:0] HEX07 [8] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07};

  // vector: {fmtHex, decode, bankSel, word[11:0], expected active-high seg[7:0]}
  localparam int NV = 14;
  localparam logic [22:0] VECS [NV] = '{
    {1'b1, 1'b1, 1'b0, 12'h083, 8'h4F},  // R5 hex 3
    {1'b1, 1'b1, 1'b0, 12'h00A, 8'hF7},  // R5 hex A, point on
    {1'b1, 1'b1, 1'b1, 12'hB8F, 8'h7C},  // R8 bank B nibble b
    {1'b1, 1'b1, 1'b0, 12'h00D, 8'hDE},  // R5 hex d, point on
    {1'b0, 1'b1, 1'b0, 12'h08A, 8'h40},  // R6 dash
    {1'b0, 1'b1, 1'b0, 12'h08C, 8'h76},  // R6 H
    {1'b0, 1'b1, 1'b1, 12'hF85, 8'h00},  // R6 blank from bank B
    {1'b0, 1'b1, 1'b1, 12'hE00, 8'hF3},  // R8 P from bank B, point on
    {1'b0, 1'b1, 1'b0, 12'h087, 8'h07},  // R6 digit 7
    {1'b1, 1'b0, 1'b0, 12'h0C0, 8'h01},  // R7 raw a only
    {1'b1, 1'b0, 1'b0, 12'h03F, 8'hFE},  // R7 raw b..g plus point
    {1'b0, 1'b0, 1'b0, 12'h080, 8'h00},  // R7 raw all off
    {1'b1, 1'b0, 1'b1, 12'hFA4, 8'h42},  // R8 bank select ignored in raw
    {1'b1, 1'b1, 1'b1, 12'h188, 8'h06}   // R8 bank B 1, bank A 8 ignored
  };

  assign rdData   = mem[rdAddr];
  assign rdDataCc = mem[rdAddrCc];

  always #10 clk = ~clk;

  led_scan_decode #(.ON_TICKS(ON_T), .GAP_TICKS(GAP_T), .COMMON_ANODE(1'b1)) u_led_scan_decode (
    .clk(clk), .rst(rst), .tick(tick), .shutdown(shutdown), .blank(blank),
    .fmtHex(fmtHex), .bankSel(bankSel), .digitDecode(digitDecode),
    .rdAddr(rdAddr), .rdData(rdData), .digitOut(digitOut), .segOut(segOut));

  led_scan_decode #(.ON_TICKS(ON_T), .GAP_TICKS(GAP_T), .COMMON_ANODE(1'b0)) u_led_scan_decode_cc (
    .clk(clk), .rst(rst), .tick(tick), .shutdown(shutdown), .blank(blank),
    .fmtHex(fmtHex), .bankSel(bankSel), .digitDecode(digitDecode),
    .rdAddr(rdAddrCc), .rdData(rdDataCc), .digitOut(digitOutCc), .segOut(segOutCc));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulseTick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    if (!shutdown) begin
      if (mCnt == (mOn ? ON_T : GAP_T) - 1) begin
        mCnt = 0;
        if (mOn) mSlot = (mSlot + 1) % 8;
        mOn = ~mOn;
      end else begin
        mCnt++;
      end
    end
  endtask

  task automatic advanceToOn();
    do pulseTick(); while (!(mOn && mCnt == 0));
    settle();
  endtask

  task automatic checkLit(input string req, input logic [7:0] expSeg);
    logic [7:0] hot;
    hot = 8'h01 << ORDER[mSlot];
    check(req, {digitOut, segOut}, {hot, ~expSeg});
    check({req, " R12 cathode"}, {digitOutCc, segOutCc}, {~hot, expSeg});
  endtask

  task automatic checkDark(input string req);
    check(req, {digitOut, segOut}, {8'h00, 8'hFF});
    check({req, " R12 cathode"}, {digitOutCc, segOutCc}, {8'hFF, 8'h00});
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mem[i] = 12'h080 | 12'(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    checkDark("R1 reset off");

    // R3 order and address mapping, first lit digit after reset is 2 (R1)
    for (int s = 0; s < 8; s++) begin
      advanceToOn();
      checkLit("R3 scan order", {1'b0, HEX07[ORDER[mSlot]]});
    end

    // R2 lit duration and R4 gap
    advanceToOn();
    repeat (ON_T - 1) pulseTick();
    settle();
    checkLit("R2 still lit", {1'b0, HEX07[ORDER[mSlot]]});
    pulseTick();
    settle();
    checkDark("R4 gap dark");
    repeat (GAP_T - 1) pulseTick();
    settle();
    checkDark("R2 gap length");

    // vector table
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < 8; i++) mem[i] = VECS[v][19:8];
      fmtHex      = VECS[v][22];
      digitDecode = VECS[v][21] ? 8'hFF : 8'h00;
      bankSel     = VECS[v][20];
      advanceToOn();
      checkLit($sformatf("R5-vector %0d (R6 R7 R8)", v), VECS[v][7:0]);
    end

    // R9 per-digit flag: only digit 1 decoded
    for (int i = 0; i < 8; i++) mem[i] = 12'h0C0;
    fmtHex = 1'b1; bankSel = 1'b0; digitDecode = 8'h01;
    for (int s = 0; s < 8; s++) begin
      advanceToOn();
      checkLit("R9 per digit flag", (ORDER[mSlot] == 0) ? 8'h3F : 8'h01);
    end

    // R10 shutdown freezes and resumes
    digitDecode = 8'hFF;
    for (int i = 0; i < 8; i++) mem[i] = 12'h080 | 12'(i);
    advanceToOn();
    shutdown = 1'b1;
    settle();
    checkDark("R10 shutdown dark");
    repeat (6) pulseTick();
    settle();
    checkDark("R10 shutdown held");
    shutdown = 1'b0;
    settle();
    checkLit("R10 resume same digit", {1'b0, HEX07[ORDER[mSlot]]});

    // R11 blank keeps scanning
    blank = 1'b1;
    settle();
    checkDark("R11 blank dark");
    advanceToOn();
    checkDark("R11 blank across digits");
    blank = 1'b0;
    settle();
    checkLit("R11 scan moved on", {1'b0, HEX07[ORDER[mSlot]]});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule